// File: doc/BRIEF.md
# Power management wake sequencer

This block brings a low-power system out of its deepest sleep state. While asleep it watches two wake sources: any change of level on the power button, and a held modem carrier-detect interrupt. When either one fires, it raises a request for the secondary memory supply rail. It then holds the processor core and the on-chip peripherals in reset until the main and memory supply-good inputs have both stayed high for a programmable number of consecutive cycles.

Once the system is running, a halt watchdog counts cycles. Software restarts the count through a control bit. If the count runs out, the block forces a shutdown back to sleep and sets a sticky timeout flag. That flag stays set through the next power-on, so software can find out why the system went down, and software clears it explicitly. Software can also send the system back to sleep at any time through a dedicated control bit.

Register map, with an 8-bit data bus:
- Control, address 0, write-only strobes. Bit 0 restarts the watchdog. Bit 1 requests sleep.
- Status, address 1. Bit 0 is the timeout flag. Writing 1 to bit 0 clears it.
- Stability count, address 2. An 8-bit read/write value that resets to 16.

Top module: `pmu_wake_seq`

## Requirements
- R1: After reset, mem_supply_req is 0, core_rst_n and periph_rst_n are 0, status bit 0 (address 1) reads 0, and the stability count (address 2) reads 16.
- R2: A change of level on pwr_btn, in either direction, while asleep raises mem_supply_req on the third rising clock edge after the change, and not before.
- R3: A high level on carrier_det while asleep raises mem_supply_req on the third rising edge after it goes high.
- R4: core_rst_n and periph_rst_n go high together on the N-th consecutive rising edge at which good_main and good_mem are both high, where N is the stability count written at address 2.
- R5: A low on either supply-good input during the stability wait restarts the count from zero.
- R6: Once a power-on sequence has started, further wake events are ignored. No stale wake is kept for the next sleep period.
- R7: Writing 1 to control bit 1 (address 0) while running returns the block to sleep on that edge: mem_supply_req goes to 0 and both resets are asserted. The same write while asleep has no effect.
- R8: While running, if no restart occurs for WDT_LIMIT cycles, the block shuts down to sleep and sets status bit 0.
- R9: Writing 1 to control bit 0 (address 0) restarts the watchdog, so shutdown comes WDT_LIMIT cycles after that write.
- R10: Status bit 0 survives a later power-on and a write of 0 to it. Only a write of 1 to status bit 0 (address 1) clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_btn | input | 1 | Power button, asynchronous; any change of level is a wake event |
| carrier_det | input | 1 | Modem carrier-detect interrupt, level-sensitive wake |
| good_main | input | 1 | Main (3.3 V) supply stable |
| good_mem | input | 1 | Memory (2.5 V) supply stable |
| mem_supply_req | output | 1 | Request to enable the memory supply rail |
| core_rst_n | output | 1 | Active-low reset to the processor core |
| periph_rst_n | output | 1 | Active-low reset to the on-chip peripherals |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |

## Verification
The checker tests several properties on every cycle. Reset is never released without the supply request. The release edge follows a cycle in which both supplies were good. The stability wait only moves forward to the running state. The timeout flag never drops without a clearing write. Leaving the running state without a sleep request always leaves the flag set.

The exact latencies need the bench's scenarios. These include the three-edge wake path from each source and the N-edge stability count with and without a supply drop. They also include the WDT_LIMIT shutdown window and how a restart moves it, the flag surviving a new power-on, and the fact that wake events arriving during a sequence leave no trace.

// File: rtl/pmu_wake_pkg.sv
package pmu_wake_pkg;
   typedef enum logic [1:0] {
      PW_SLEEP = 2'd0,
      PW_RAMP  = 2'd1,
      PW_RUN   = 2'd2
   } pw_state_e;

   localparam int          REG_AW          = 2;
   localparam logic [1:0]  REG_CTRL        = 2'd0;
   localparam logic [1:0]  REG_STAT        = 2'd1;
   localparam logic [1:0]  REG_STAB        = 2'd2;
   localparam int          CTRL_RESTART_B  = 0;
   localparam int          CTRL_ENTER_B    = 1;
   localparam int          STAT_TMO_B      = 0;
endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmu_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pmu_stable_timer.sv
module pmu_stable_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          ok,
   input  logic [CW-1:0] limit,
   output logic          done
);
   logic [CW-1:0] cnt;
   logic [CW:0]   next_cnt;

   assign next_cnt = {1'b0, cnt} + 1'b1;
   assign done     = en && ok && (next_cnt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!en || !ok || done)  cnt <= '0;
      else if (cnt != '1)           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pmu_halt_wdt.sv
module pmu_halt_wdt #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expire
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   if (LIMIT < 2) begin : g_bad_limit
      $error("pmu_halt_wdt: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign expire = run && !restart && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!run || restart || expire) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pmu_wake_seq.sv
module pmu_wake_seq
   import pmu_wake_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int STAB_W       = 8,
   parameter int STAB_RESET   = 16,
   parameter int WDT_LIMIT    = 1024,
   parameter int DATA_W       = 8,
   parameter bit SYNC_CARRIER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_btn,
   input  logic              carrier_det,
   input  logic              good_main,
   input  logic              good_mem,
   output logic              mem_supply_req,
   output logic              core_rst_n,
   output logic              periph_rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   if (DATA_W < 2 || STAB_W > DATA_W) begin : g_bad_width
      $error("pmu_wake_seq: need 2 <= DATA_W and STAB_W <= DATA_W");
   end
   if (STAB_RESET < 0 || STAB_RESET >= (1 << STAB_W)) begin : g_bad_stab
      $error("pmu_wake_seq: STAB_RESET does not fit STAB_W");
   end

   pw_state_e   state_q, state_d;
   logic        btn_s, btn_d, btn_edge, car_s, wake;
   logic        stab_done, wdt_expire, tmo_q;
   logic [STAB_W-1:0] stab_q;
   logic        wr_ctrl, wr_stat, wr_stab;
   logic        restart_req, enter_req, clr_tmo;

   // wake sources
   pmu_sync #(.STAGES(SYNC_STAGES), .W(1)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .d(pwr_btn), .q(btn_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) btn_d <= 1'b0;
      else        btn_d <= btn_s;
   end
   assign btn_edge = btn_s ^ btn_d;

   if (SYNC_CARRIER) begin : g_car_sync
      pmu_sync #(.STAGES(SYNC_STAGES), .W(1)) u_car_sync (
         .clk(clk), .rst_n(rst_n), .d(carrier_det), .q(car_s));
   end else begin : g_car_direct
      assign car_s = carrier_det;
   end

   assign wake = btn_edge || car_s;

   // register decode
   assign wr_ctrl     = bus_sel && bus_we && (bus_addr == REG_CTRL);
   assign wr_stat     = bus_sel && bus_we && (bus_addr == REG_STAT);
   assign wr_stab     = bus_sel && bus_we && (bus_addr == REG_STAB);
   assign restart_req = wr_ctrl && bus_wdata[CTRL_RESTART_B];
   assign enter_req   = wr_ctrl && bus_wdata[CTRL_ENTER_B];
   assign clr_tmo     = wr_stat && bus_wdata[STAT_TMO_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stab_q <= STAB_W'(STAB_RESET);
      else if (wr_stab) stab_q <= bus_wdata[STAB_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tmo_q <= 1'b0;
      else if (wdt_expire) tmo_q <= 1'b1;
      else if (clr_tmo)    tmo_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_STAT: bus_rdata[STAT_TMO_B] = tmo_q;
         REG_STAB: bus_rdata = DATA_W'(stab_q);
         default:  bus_rdata = '0;
      endcase
   end

   // supply stability and halt watchdog
   pmu_stable_timer #(.CW(STAB_W)) u_stab (
      .clk(clk), .rst_n(rst_n), .en(state_q == PW_RAMP),
      .ok(good_main && good_mem), .limit(stab_q), .done(stab_done));

   pmu_halt_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
      .clk(clk), .rst_n(rst_n), .run(state_q == PW_RUN),
      .restart(restart_req), .expire(wdt_expire));

   // sequencer
   always_comb begin
      state_d = state_q;
      case (state_q)
         PW_SLEEP: if (wake)                    state_d = PW_RAMP;
         PW_RAMP:  if (stab_done)               state_d = PW_RUN;
         PW_RUN:   if (wdt_expire || enter_req) state_d = PW_SLEEP;
         default:                               state_d = PW_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PW_SLEEP;
      else        state_q <= state_d;
   end

   assign mem_supply_req = (state_q != PW_SLEEP);
   assign core_rst_n     = (state_q == PW_RUN);
   assign periph_rst_n   = (state_q == PW_RUN);
endmodule

// File: rtl/pmu_wake_seq_chk.sv
module pmu_wake_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       good_main,
   input logic       good_mem,
   input logic       mem_supply_req,
   input logic       core_rst_n,
   input logic       bus_sel,
   input logic       bus_we,
   input logic [1:0] bus_addr,
   input logic [1:0] wdata_lo,
   input logic       tmo_flag
);
   logic enter_wr, clear_wr;
   assign enter_wr = bus_sel && bus_we && (bus_addr == 2'd0) && wdata_lo[1];
   assign clear_wr = bus_sel && bus_we && (bus_addr == 2'd1) && wdata_lo[0];

   assert_rst_needs_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_supply_req |-> !core_rst_n);

   assert_release_after_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n) |-> $past(good_main && good_mem));

   assert_ramp_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_supply_req && !core_rst_n) |=> mem_supply_req);

   assert_tmo_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag && !clear_wr) |=> tmo_flag);

   assert_shutdown_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_n && !enter_wr) |=> (core_rst_n || tmo_flag));
endmodule

bind pmu_wake_seq pmu_wake_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .good_main(good_main), .good_mem(good_mem),
   .mem_supply_req(mem_supply_req), .core_rst_n(core_rst_n),
   .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
   .wdata_lo(bus_wdata[1:0]), .tmo_flag(tmo_q));

// File: tb/pmu_wake_seq_test.sv
module pmu_wake_seq_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LIM = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_btn = 1'b0, carrier_det = 1'b0;
   logic       good_main = 1'b0, good_mem = 1'b0;
   logic       mem_supply_req, core_rst_n, periph_rst_n;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   string q_req[$];
   int    q_sig[$];
   int    q_val[$];
   string m_req;
   int    m_sig, m_exp, m_act;

   pmu_wake_seq #(.WDT_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_btn(pwr_btn), .carrier_det(carrier_det),
      .good_main(good_main), .good_mem(good_mem), .mem_supply_req(mem_supply_req),
      .core_rst_n(core_rst_n), .periph_rst_n(periph_rst_n), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   always #2.5 clk = ~clk;

   // monitor: pops expected items and compares away from the rising edge
   always @(negedge clk) begin
      while (q_sig.size() > 0) begin
         m_req = q_req.pop_front();
         m_sig = q_sig.pop_front();
         m_exp = q_val.pop_front();
         case (m_sig)
            0:       m_act = int'(mem_supply_req);
            1:       m_act = int'(core_rst_n);
            2:       m_act = int'(periph_rst_n);
            default: m_act = int'(bus_rdata);
         endcase
         n_tests++;
         if (m_act != m_exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", m_req, m_act, m_exp);
         end
      end
   end

   task automatic push_exp(string r, int sig, int val);
      q_req.push_back(r);
      q_sig.push_back(sig);
      q_val.push_back(val);
      wait (q_sig.size() == 0);
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick(1);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'd0;
   endtask

   task automatic rd(string r, logic [1:0] a, int e);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      push_exp(r, 3, e);
      bus_sel = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      push_exp("R1 mem_supply_req", 0, 0);
      push_exp("R1 core_rst_n", 1, 0);
      push_exp("R1 periph_rst_n", 2, 0);
      rd("R1 status", 2'd1, 0);
      rd("R1 stab count", 2'd2, 16);

      wr(2'd2, 8'd5);
      rd("R4 stab count write", 2'd2, 5);

      // R7 sleep request while asleep has no effect
      wr(2'd0, 8'h02);
      tick(3);
      push_exp("R7 enter while asleep", 0, 0);

      // R2 button wake latency
      pwr_btn = ~pwr_btn;
      tick(2);
      push_exp("R2 not before third edge", 0, 0);
      tick(1);
      push_exp("R2 wake on third edge", 0, 1);
      push_exp("R2 core held", 1, 0);

      // R6 wake ignored during stability wait
      pwr_btn = ~pwr_btn;
      tick(6);
      push_exp("R6 ramp holds req", 0, 1);
      push_exp("R6 ramp holds reset", 1, 0);

      // R4 release after N good edges
      good_main = 1'b1; good_mem = 1'b1;
      tick(4);
      push_exp("R4 still held at N-1", 1, 0);
      tick(1);
      push_exp("R4 core released at N", 1, 1);
      push_exp("R4 periph released at N", 2, 1);

      // R6 wake ignored while running
      wr(2'd0, 8'h01);
      pwr_btn = ~pwr_btn;
      tick(5);
      push_exp("R6 running unaffected", 1, 1);

      // R7 sleep request while running
      wr(2'd0, 8'h02);
      push_exp("R7 req dropped", 0, 0);
      push_exp("R7 core reset", 1, 0);
      push_exp("R7 periph reset", 2, 0);
      tick(6);
      push_exp("R6 no stale wake", 0, 0);

      // R3 carrier wake, R5 supply drop restarts count
      carrier_det = 1'b1;
      tick(2);
      push_exp("R3 not before third edge", 0, 0);
      tick(1);
      push_exp("R3 carrier wake", 0, 1);
      carrier_det = 1'b0;
      good_mem = 1'b0;
      tick(2);
      good_mem = 1'b1;
      tick(4);
      push_exp("R5 restarted count holds", 1, 0);
      tick(1);
      push_exp("R5 release after full count", 1, 1);

      // R8 watchdog shutdown
      tick(LIM - 1);
      push_exp("R8 running before limit", 1, 1);
      tick(1);
      push_exp("R8 shutdown core", 1, 0);
      push_exp("R8 shutdown req", 0, 0);
      rd("R8 flag set", 2'd1, 1);

      // R10 flag persistence
      wr(2'd1, 8'h00);
      rd("R10 write 0 keeps flag", 2'd1, 1);
      pwr_btn = ~pwr_btn;
      tick(3);
      push_exp("R2 wake again", 0, 1);
      tick(5);
      push_exp("R4 release again", 1, 1);
      rd("R10 flag survives power-on", 2'd1, 1);

      // R9 watchdog restart
      tick(10);
      wr(2'd0, 8'h01);
      tick(LIM - 1);
      push_exp("R9 restart extends run", 1, 1);
      tick(1);
      push_exp("R9 shutdown after restart", 1, 0);

      wr(2'd1, 8'h01);
      rd("R10 flag cleared", 2'd1, 0);

      done = 1'b1;
      finish_run();
   end
endmodule